// File: doc/BRIEF.md
# UART host register controller

This block is the processor-facing control side of a simple serial port. A byte-wide register bus with a 6-bit offset reaches two mode registers, a status register, a command register, the transmit and receive data ports, and an interrupt status/mask pair. The serial shifter, the baud generator and the receive FIFO sit outside. The block takes the FIFO's level and error indications as inputs and drives pop, flush and receiver-enable strobes back to it. On the transmit side it hands finished bytes to the shifter over a one-cycle strobe.

The command register packs three independent fields into one byte. The block applies the miscellaneous reset field first and the transmitter and receiver enable fields after it. A single write can therefore reset a subunit and re-enable it. The transmit side keeps one holding byte. The byte is released when the transmitter is enabled, and it waits while the transmitter is disabled. The receive interrupt source is chosen by a bit in the first mode register: either "data ready" or "FIFO full".

Top module: `uart_host_ctrl`

## Requirements
- R1: After reset the status register reads 0x08 (only bit3, transmit empty, set), the interrupt mask is 0, irq_o is low, the transmitter and receiver are disabled, cmd_err_o is low, and the mode pointer selects the first mode register.
- R2: A read or write at offset 0x00 accesses the mode register that the pointer selects. After the access the pointer moves from the first register to the second and stays there. Command field [6:4] = 1 returns the pointer to the first register.
- R3: A write to offset 0x0C clears status bit3. If the transmitter is enabled, tx_strobe_o pulses for one cycle with the byte on tx_byte_o in the cycle after the write. After that, status bit3 (empty) and bit2 (ready) are set.
- R4: While the transmitter is disabled, a byte written to 0x0C is held with no strobe, and status bits 3 and 2 stay clear. A later enable command releases the byte.
- R5: Command field [3:2] controls the transmitter: 1 enables it, 2 disables it and clears status bit2, 3 is reserved. The reserved code leaves the enable state unchanged and sets the sticky cmd_err_o.
- R6: Command field [1:0] controls the receiver with the same encoding (1 on, 2 off, 3 reserved with cmd_err_o set and state kept), visible on rx_en_o.
- R7: Command field [6:4] = 2 clears rx_en_o and pulses rx_flush_o in the write cycle. Field value 3 disables the transmitter, sets status bit3, clears bit2 and discards any held byte.
- R8: Each rx_err_i bit (0 overrun, 1 parity, 2 framing, 3 break) sets the sticky status bit 4, 5, 6 or 7. Command field [6:4] = 4 clears those four bits and cmd_err_o.
- R9: The interrupt status at 0x14 holds: bit0 = status bit2; bit1 = status bit1 if mode register one bit6 is set, otherwise status bit0; bit2 = delta-break, set by break_evt_i and cleared by command field [6:4] = 5; bit7 = cos_i.
- R10: A write to 0x14 loads the interrupt mask. irq_o is high exactly when interrupt status AND mask is nonzero.
- R11: Within one command write the reset field acts before the enable fields, so 0x34 leaves the transmitter enabled. Field codes 6 and 7 change nothing.
- R12: Status bits 0 and 1 mirror rx_ready_i and rx_full_i. A read at 0x0C returns rx_data_i and pulses rx_pop_o only when rx_ready_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of rd_en_i |
| rx_ready_i | input | 1 | Receive FIFO holds data |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_data_i | input | 8 | Byte at the FIFO head |
| rx_err_i | input | 4 | Error pulses: overrun, parity, framing, break |
| break_evt_i | input | 1 | Line break change pulse |
| cos_i | input | 1 | Change-of-state level |
| rx_pop_o | output | 1 | Pop the FIFO head |
| rx_flush_o | output | 1 | Empty the FIFO |
| rx_en_o | output | 1 | Receiver enabled |
| tx_byte_o | output | 8 | Byte handed to the shifter |
| tx_strobe_o | output | 1 | One-cycle transmit strobe |
| irq_o | output | 1 | Interrupt request |
| cmd_err_o | output | 1 | Sticky reserved-command flag |

## Verification
The assertions check the cycle-level invariants on every cycle. The mode pointer only moves back on a pointer-reset command and never passes the last register. The transmit strobe only fires from an enabled transmitter, and it leaves the holding buffer empty. Transmit ready is never set without enable. Sticky error bits only fall on a clear command, receiver enable only rises on an enable command, and an all-zero mask keeps the interrupt low. The bench's scenarios are needed for the rest: the ordering of fields inside one command byte, the discarding of a held byte by a transmitter reset, the release of a held byte by a later enable, and the selection of the receive interrupt source by the mode bit.

// File: rtl/uart_hc_pkg.sv
package uart_hc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int ERR_W  = 4;

  localparam int OFS_MODE = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CMD  = 'h08;
  localparam int OFS_DATA = 'h0C;
  localparam int OFS_INT  = 'h14;

  // status bit positions
  localparam int ST_RX_RDY  = 0;
  localparam int ST_RX_FULL = 1;
  localparam int ST_TX_RDY  = 2;
  localparam int ST_TX_EMP  = 3;
  localparam int ST_ERR_LO  = 4;

  // interrupt bit positions
  localparam int IS_TX   = 0;
  localparam int IS_RX   = 1;
  localparam int IS_DBRK = 2;
  localparam int IS_COS  = 7;

  localparam int RX_SEL_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NOP, MISC_PTR_RST, MISC_RX_RST, MISC_TX_RST,
    MISC_ERR_RST, MISC_DBRK_CLR, MISC_BRK_ON, MISC_BRK_OFF
  } misc_cmd_e;

  typedef enum logic [1:0] {EN_NOP, EN_ON, EN_OFF, EN_RSVD} en_cmd_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic dbrk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
    logic bad;
  } cmd_t;
endpackage

// File: rtl/uart_hc_cmd_dec.sv
module uart_hc_cmd_dec
  import uart_hc_pkg::*;
(
  input  logic       cmd_we_i,
  input  logic [6:0] cmd_i,
  output cmd_t       cmd_o
);
  misc_cmd_e misc;
  en_cmd_e   tx_f, rx_f;

  assign misc = misc_cmd_e'(cmd_i[6:4]);
  assign tx_f = en_cmd_e'(cmd_i[3:2]);
  assign rx_f = en_cmd_e'(cmd_i[1:0]);

  always_comb begin
    cmd_o = '0;
    if (cmd_we_i) begin
      unique case (misc)
        MISC_PTR_RST:  cmd_o.ptr_rst  = 1'b1;
        MISC_RX_RST:   cmd_o.rx_rst   = 1'b1;
        MISC_TX_RST:   cmd_o.tx_rst   = 1'b1;
        MISC_ERR_RST:  cmd_o.err_rst  = 1'b1;
        MISC_DBRK_CLR: cmd_o.dbrk_clr = 1'b1;
        default: ;  // nop and break line codes: no action
      endcase
      cmd_o.tx_on  = (tx_f == EN_ON);
      cmd_o.tx_off = (tx_f == EN_OFF);
      cmd_o.rx_on  = (rx_f == EN_ON);
      cmd_o.rx_off = (rx_f == EN_OFF);
      cmd_o.bad    = (tx_f == EN_RSVD) || (rx_f == EN_RSVD);
    end
  end
endmodule

// File: rtl/uart_hc_mode_regs.sv
module uart_hc_mode_regs
  import uart_hc_pkg::*;
#(
  parameter int N_MR = 2,
  localparam int PTR_W = (N_MR > 1) ? $clog2(N_MR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ptr_rst_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rx_sel_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_MR - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] mr_q [N_MR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_q <= '0;
    else if (ptr_rst_i)             ptr_q <= '0;
    else if (acc_i && ptr_q != PTR_LAST) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_MR; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mr_q[g] <= '0;
      else if (we_i && ptr_q == PTR_W'(g))       mr_q[g] <= wdata_i;
    end
  end

  assign rdata_o  = mr_q[ptr_q];
  assign rx_sel_o = mr_q[0][RX_SEL_BIT];

  assert_ptr_back_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q < $past(ptr_q)) |-> $past(ptr_rst_i));
  assert_ptr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_LAST);
endmodule

// File: rtl/uart_hc_tx_hold.sv
module uart_hc_tx_hold
  import uart_hc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_we_i,
  input  logic [DATA_W-1:0] tb_data_i,
  input  logic              tx_on_i,
  input  logic              tx_off_i,
  input  logic              tx_rst_i,
  output logic              tx_empty_o,
  output logic              tx_rdy_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_strobe_o
);
  logic en_q, en_d, empty_q, empty_d, rdy_q, rdy_d, strobe_q, fire;
  logic [DATA_W-1:0] buf_q, buf_d, byte_q;

  assign fire = en_q && !empty_q && !tb_we_i;

  always_comb begin
    en_d = en_q; empty_d = empty_q; rdy_d = rdy_q; buf_d = buf_q;
    if (tb_we_i) begin
      buf_d = tb_data_i; empty_d = 1'b0; rdy_d = 1'b0;
    end
    if (fire) begin
      empty_d = 1'b1; rdy_d = 1'b1;
    end
    if (tx_rst_i) begin
      en_d = 1'b0; empty_d = 1'b1; rdy_d = 1'b0;
    end
    // enable field applies after the reset field
    if (tx_on_i) begin
      en_d = 1'b1; rdy_d = empty_d;
    end
    if (tx_off_i) begin
      en_d = 1'b0; rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; empty_q <= 1'b1; rdy_q <= 1'b0;
      buf_q <= '0; byte_q <= '0; strobe_q <= 1'b0;
    end else begin
      en_q <= en_d; empty_q <= empty_d; rdy_q <= rdy_d; buf_q <= buf_d;
      strobe_q <= fire;
      if (fire) byte_q <= buf_q;
    end
  end

  assign tx_empty_o  = empty_q;
  assign tx_rdy_o    = rdy_q;
  assign tx_byte_o   = byte_q;
  assign tx_strobe_o = strobe_q;

  assert_strobe_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> tx_empty_o);
  assert_strobe_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> $past(en_q));
  assert_rdy_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rdy_o |-> en_q);
endmodule

// File: rtl/uart_hc_rx_ctrl.sv
module uart_hc_rx_ctrl
  import uart_hc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_on_i,
  input  logic             rx_off_i,
  input  logic             rx_rst_i,
  input  logic             err_rst_i,
  input  logic             dbrk_clr_i,
  input  logic             break_evt_i,
  input  logic [ERR_W-1:0] rx_err_i,
  output logic             rx_en_o,
  output logic [ERR_W-1:0] err_o,
  output logic             dbrk_o
);
  logic             en_q, dbrk_q;
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (rx_on_i) en_q <= 1'b1;
    else if (rx_off_i || rx_rst_i) en_q <= 1'b0;
  end

  for (genvar g = 0; g < ERR_W; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          err_q[g] <= 1'b0;
      else if (rx_err_i[g]) err_q[g] <= 1'b1;
      else if (err_rst_i)   err_q[g] <= 1'b0;
    end
    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_q[g]) |-> $past(err_rst_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dbrk_q <= 1'b0;
    else if (break_evt_i) dbrk_q <= 1'b1;
    else if (dbrk_clr_i)  dbrk_q <= 1'b0;
  end

  assign rx_en_o = en_q;
  assign err_o   = err_q;
  assign dbrk_o  = dbrk_q;

  assert_rx_en_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> $past(rx_on_i));
  assert_dbrk_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dbrk_o) |-> $past(dbrk_clr_i));
endmodule

// File: rtl/uart_host_ctrl.sv
module uart_host_ctrl
  import uart_hc_pkg::*;
#(
  parameter int N_MR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_ready_i,
  input  logic              rx_full_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  input  logic              break_evt_i,
  input  logic              cos_i,
  output logic              rx_pop_o,
  output logic              rx_flush_o,
  output logic              rx_en_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_strobe_o,
  output logic              irq_o,
  output logic              cmd_err_o
);
  logic hit_mode, hit_stat, hit_cmd, hit_data, hit_int;
  assign hit_mode = addr_i == ADDR_W'(OFS_MODE);
  assign hit_stat = addr_i == ADDR_W'(OFS_STAT);
  assign hit_cmd  = addr_i == ADDR_W'(OFS_CMD);
  assign hit_data = addr_i == ADDR_W'(OFS_DATA);
  assign hit_int  = addr_i == ADDR_W'(OFS_INT);

  cmd_t cmd;
  logic [DATA_W-1:0] mr_rdata, stat, isr, imr_q;
  logic rx_sel, tx_empty, tx_rdy, dbrk, cerr_q;
  logic [ERR_W-1:0] err;

  uart_hc_cmd_dec u_dec (
    .cmd_we_i (wr_en_i && hit_cmd),
    .cmd_i    (wdata_i[6:0]),
    .cmd_o    (cmd)
  );

  uart_hc_mode_regs #(.N_MR(N_MR)) u_mode (
    .clk_i, .rst_ni,
    .acc_i     ((wr_en_i || rd_en_i) && hit_mode),
    .we_i      (wr_en_i && hit_mode),
    .wdata_i,
    .ptr_rst_i (cmd.ptr_rst),
    .rdata_o   (mr_rdata),
    .rx_sel_o  (rx_sel)
  );

  uart_hc_tx_hold u_tx (
    .clk_i, .rst_ni,
    .tb_we_i     (wr_en_i && hit_data),
    .tb_data_i   (wdata_i),
    .tx_on_i     (cmd.tx_on),
    .tx_off_i    (cmd.tx_off),
    .tx_rst_i    (cmd.tx_rst),
    .tx_empty_o  (tx_empty),
    .tx_rdy_o    (tx_rdy),
    .tx_byte_o,
    .tx_strobe_o
  );

  uart_hc_rx_ctrl u_rx (
    .clk_i, .rst_ni,
    .rx_on_i     (cmd.rx_on),
    .rx_off_i    (cmd.rx_off),
    .rx_rst_i    (cmd.rx_rst),
    .err_rst_i   (cmd.err_rst),
    .dbrk_clr_i  (cmd.dbrk_clr),
    .break_evt_i,
    .rx_err_i,
    .rx_en_o,
    .err_o       (err),
    .dbrk_o      (dbrk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                imr_q <= '0;
    else if (wr_en_i && hit_int) imr_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cerr_q <= 1'b0;
    else if (cmd.bad)     cerr_q <= 1'b1;
    else if (cmd.err_rst) cerr_q <= 1'b0;
  end

  always_comb begin
    stat = '0;
    stat[ST_RX_RDY]  = rx_ready_i;
    stat[ST_RX_FULL] = rx_full_i;
    stat[ST_TX_RDY]  = tx_rdy;
    stat[ST_TX_EMP]  = tx_empty;
    stat[ST_ERR_LO +: ERR_W] = err;
  end

  always_comb begin
    isr = '0;
    isr[IS_TX]   = tx_rdy;
    isr[IS_RX]   = rx_sel ? rx_full_i : rx_ready_i;
    isr[IS_DBRK] = dbrk;
    isr[IS_COS]  = cos_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_mode)      rdata_o = mr_rdata;
      else if (hit_stat) rdata_o = stat;
      else if (hit_data) rdata_o = rx_data_i;
      else if (hit_int)  rdata_o = isr;
    end
  end

  assign rx_pop_o   = rd_en_i && hit_data && rx_ready_i;
  assign rx_flush_o = cmd.rx_rst;
  assign irq_o      = |(isr & imr_q);
  assign cmd_err_o  = cerr_q;

  assert_no_irq_unmasked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '0) |-> !irq_o);
  assert_cmd_err_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_err_o) |-> $past(wr_en_i && hit_cmd));
endmodule

// File: tb/tb_uart_host_ctrl.sv
module tb_uart_host_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, rd_en_i = 0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o, rx_data_i = '0, tx_byte_o;
  logic rx_ready_i = 0, rx_full_i = 0, break_evt_i = 0, cos_i = 0;
  logic [3:0] rx_err_i = '0;
  logic rx_pop_o, rx_flush_o, rx_en_o, tx_strobe_o, irq_o, cmd_err_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  uart_host_ctrl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic flush_seen, pop_seen;

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    #1 flush_seen = rx_flush_o;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1; addr_i = a;
    #1 d = rdata_o; pop_seen = rx_pop_o;
    @(negedge clk_i);
    rd_en_i = 0;
  endtask

  task automatic send(input logic [7:0] d);
    exp_q.push_back(d);
    wr(6'h0C, d);
  endtask

  // monitor: compares emitted bytes with the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && tx_strobe_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected strobe act=%h exp=none", tx_byte_o);
      end else chk("R3 tx byte", tx_byte_o, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1
    rd(6'h04, v); chk("R1 status", v, 8'h08);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    chk("R1 rx_en", {7'b0, rx_en_o}, 8'h00);
    chk("R1 cmd_err", {7'b0, cmd_err_o}, 8'h00);
    rd(6'h14, v); chk("R1 isr", v, 8'h00);
    // R2
    wr(6'h00, 8'h11); wr(6'h00, 8'h22);
    rd(6'h00, v); chk("R2 second mode reg", v, 8'h22);
    wr(6'h08, 8'h10);
    rd(6'h00, v); chk("R2 ptr reset to first", v, 8'h11);
    rd(6'h00, v); chk("R2 read advances ptr", v, 8'h22);
    // R4 held while disabled
    wr(6'h0C, 8'hA5);
    rd(6'h04, v); chk("R4 held status", v, 8'h00);
    exp_q.push_back(8'hA5);
    wr(6'h08, 8'h04);
    rd(6'h04, v); chk("R4 released status", v, 8'h0C);
    // R3 enabled transfers
    send(8'h3C);
    rd(6'h04, v); chk("R3 status after tx", v, 8'h0C);
    send(8'h5A);
    // R5 disable and reserved
    wr(6'h08, 8'h08);
    rd(6'h04, v); chk("R5 disabled status", v, 8'h08);
    wr(6'h08, 8'h0C);
    chk("R5 cmd_err set", {7'b0, cmd_err_o}, 8'h01);
    rd(6'h04, v); chk("R5 reserved keeps disabled", v, 8'h08);
    wr(6'h08, 8'h40);
    chk("R8 cmd_err cleared", {7'b0, cmd_err_o}, 8'h00);
    wr(6'h08, 8'h04); wr(6'h08, 8'h0C);
    rd(6'h04, v); chk("R5 reserved keeps enabled", v, 8'h0C);
    send(8'hC3);
    wr(6'h08, 8'h40);
    // R7 tx reset discards held byte
    wr(6'h08, 8'h08); wr(6'h0C, 8'h77);
    rd(6'h04, v); chk("R7 held before reset", v, 8'h00);
    wr(6'h08, 8'h30);
    rd(6'h04, v); chk("R7 tx reset status", v, 8'h08);
    wr(6'h08, 8'h04);
    rd(6'h04, v); chk("R7 nothing sent after reset", v, 8'h0C);
    // R11 ordering and no-op codes
    wr(6'h08, 8'h08); wr(6'h08, 8'h34);
    rd(6'h04, v); chk("R11 reset then enable", v, 8'h0C);
    wr(6'h08, 8'h60); wr(6'h08, 8'h70);
    rd(6'h04, v); chk("R11 break codes no effect", v, 8'h0C);
    rd(6'h00, v); chk("R11 ptr untouched", v, 8'h22);
    // R6 receiver field
    wr(6'h08, 8'h01); chk("R6 rx on", {7'b0, rx_en_o}, 8'h01);
    wr(6'h08, 8'h03); chk("R6 reserved keeps on", {7'b0, rx_en_o}, 8'h01);
    chk("R6 cmd_err", {7'b0, cmd_err_o}, 8'h01);
    wr(6'h08, 8'h02); chk("R6 rx off", {7'b0, rx_en_o}, 8'h00);
    wr(6'h08, 8'h01);
    wr(6'h08, 8'h20);
    chk("R7 flush pulse", {7'b0, flush_seen}, 8'h01);
    chk("R7 rx off after reset", {7'b0, rx_en_o}, 8'h00);
    wr(6'h08, 8'h40);
    // R8 sticky errors
    @(negedge clk_i); rx_err_i = 4'b0101;
    @(negedge clk_i); rx_err_i = 4'b0000;
    rd(6'h04, v); chk("R8 error bits", v, 8'h5C);
    wr(6'h08, 8'h40);
    rd(6'h04, v); chk("R8 errors cleared", v, 8'h0C);
    // R12 receive data
    rx_ready_i = 1; rx_data_i = 8'h9E;
    rd(6'h04, v); chk("R12 rx ready bit", v, 8'h0D);
    rd(6'h0C, v); chk("R12 rx data", v, 8'h9E);
    chk("R12 pop", {7'b0, pop_seen}, 8'h01);
    rx_ready_i = 0;
    rd(6'h0C, v); chk("R12 no pop when empty", {7'b0, pop_seen}, 8'h00);
    // R9 interrupt status
    rx_ready_i = 1;
    rd(6'h14, v); chk("R9 isr ready source", v, 8'h03);
    wr(6'h08, 8'h10); wr(6'h00, 8'h51);
    rd(6'h14, v); chk("R9 isr full source", v, 8'h01);
    rx_full_i = 1;
    rd(6'h14, v); chk("R9 isr full set", v, 8'h03);
    @(negedge clk_i); break_evt_i = 1;
    @(negedge clk_i); break_evt_i = 0; cos_i = 1;
    rd(6'h14, v); chk("R9 isr break and cos", v, 8'h87);
    wr(6'h08, 8'h50);
    rd(6'h14, v); chk("R9 delta-break cleared", v, 8'h83);
    // R10 mask
    chk("R10 irq masked", {7'b0, irq_o}, 8'h00);
    wr(6'h14, 8'h04);
    chk("R10 irq no dbrk", {7'b0, irq_o}, 8'h00);
    @(negedge clk_i); break_evt_i = 1;
    @(negedge clk_i); break_evt_i = 0;
    chk("R10 irq on dbrk", {7'b0, irq_o}, 8'h01);
    wr(6'h14, 8'h80);
    chk("R10 irq on cos", {7'b0, irq_o}, 8'h01);
    cos_i = 0; #1;
    chk("R10 irq cos low", {7'b0, irq_o}, 8'h00);
    repeat (4) @(negedge clk_i);
    chk("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule